// File: doc/BRIEF.md
# FIFO Flag Offset Register Unit

This unit keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against: the empty offset and the full offset. While master reset is held, it samples a load strap and two select straps. The load strap picks how the offsets are programmed afterwards (one bit at a time or one word at a time). The three straps together pick one of eight default values, and that default is preloaded into both offsets whichever mode was chosen.

After reset, any access made with the load input low goes to the offset registers and not to the FIFO memory. In word mode, each write stores the low bits of the data bus into the next offset. In bit mode, each write stores the serial input into the next bit position. Reads return whole words on the readback bus, and this holds in both modes. A single write pointer and a separate read pointer each step through the empty offset, then the full offset, and then back to the empty offset.

The write side is a four-state machine clocked by the write clock: `WS_PAR_EMPTY`, `WS_PAR_FULL`, `WS_SER_EMPTY` and `WS_SER_FULL`. Reset enters `WS_SER_EMPTY` when the load strap is high and `WS_PAR_EMPTY` when it is low. In word mode, every offset write moves `WS_PAR_EMPTY`→`WS_PAR_FULL` and `WS_PAR_FULL`→`WS_PAR_EMPTY`. In bit mode, the machine moves `WS_SER_EMPTY`→`WS_SER_FULL` and `WS_SER_FULL`→`WS_SER_EMPTY` only on the write that fills the most significant bit. Otherwise it stays in its state and advances a bit counter. The read side is a two-state machine clocked by the read clock, `RS_EMPTY` and `RS_FULL`. It toggles between them on every offset read, and reset returns it to `RS_EMPTY`.

Top module: `ofs_flag_regs`

## Requirements
- R1: The level of `ld` at a write-clock edge with `mrst` high selects the mode. 1 selects bit (serial) mode, and 0 selects word (parallel) mode.
- R2: A write-clock edge with `mrst` high loads both offsets with a default chosen by {ld,sel1,sel0}: 100=1023, 010=511, 001=255, 000=127, 011=63, 110=31, 101=15, 111=7.
- R3: In word mode, a write-clock edge with `ld`=0 and `wen`=1 stores `wdata` into the offset selected by the write pointer. The writes alternate: empty offset, then full offset, then empty offset again. The first write after reset goes to the empty offset.
- R4: In bit mode, a write-clock edge with `ld`=0 and `wen`=1 stores `sdin` into the next bit. The order runs from the empty offset's bit 0 up to its MSB, then from the full offset's bit 0 up to its MSB, and then wraps back to the empty offset's bit 0. Each such write changes at most one offset bit.
- R5: In bit mode, `wdata` has no effect on the offsets. In word mode, `sdin` has no effect on the offsets.
- R6: A write-clock edge with `ld`=1 leaves both offsets and the write pointer unchanged.
- R7: A read-clock edge with `ld`=0 and `ren`=1 places an offset on `rdata`, taking the value the offset held before that edge. The reads alternate empty offset, full offset, empty offset, starting with the empty offset after reset, and this holds in both modes.
- R8: A read-clock edge with `ld`=1 leaves `rdata` and the read pointer unchanged.
- R9: `rdata` is 0 after a read-clock edge with `mrst` high.
- R10: Reset restarts both pointers and the bit counter at the empty offset's bit 0, including when it arrives part way through a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous to each clock |
| ld | input | 1 | Mode strap during reset; afterwards 0 routes accesses to the offsets |
| sel1 | input | 1 | Default-select strap, upper bit |
| sel0 | input | 1 | Default-select strap, lower bit |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| sdin | input | 1 | Serial offset bit |
| wdata | input | OFS_W | Parallel offset word |
| empty_ofs | output | OFS_W | Current almost-empty offset |
| full_ofs | output | OFS_W | Current almost-full offset |
| rdata | output | OFS_W | Offset readback word |

## Verification
The assertions check four things on every cycle. With `ld` high, the offsets and the readback word stay frozen. A bit-mode write changes at most one offset bit. A word-mode write lands in one of the two offsets. Every readback word equals one of the offsets from the previous cycle. The bench scenarios are needed to show the exact default chosen by each of the eight strap combinations, the empty-then-full order of both pointers, and the bit ordering across the boundary between the two offsets. They also show that the unused data source has no effect and that a reset in the middle of a sequence restarts the pointers.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        WS_PAR_EMPTY = 2'd0,
        WS_PAR_FULL  = 2'd1,
        WS_SER_EMPTY = 2'd2,
        WS_SER_FULL  = 2'd3
    } wr_state_e;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_FULL  = 1'b1
    } rd_state_e;

    // Default offset chosen by the straps {ld, sel1, sel0}.
    function automatic int unsigned default_offset(input logic [2:0] strap);
        int unsigned v;
        unique case (strap)
            3'b100:  v = 1023;
            3'b010:  v = 511;
            3'b001:  v = 255;
            3'b000:  v = 127;
            3'b011:  v = 63;
            3'b110:  v = 31;
            3'b101:  v = 15;
            default: v = 7;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             wclk,
    input  logic             mrst,
    input  logic             ld,
    input  logic             sel1,
    input  logic             sel0,
    input  logic             wen,
    input  logic             sdin,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic             ser_mode
);

    localparam int CNT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OFS_W - 1);

    wr_state_e        state_q, state_d;
    logic [CNT_W-1:0] bit_q;
    logic             hit;
    logic             last_bit;
    logic             upd_empty_par, upd_full_par;
    logic             upd_empty_ser, upd_full_ser;
    logic [OFS_W-1:0] dflt;

    assign hit      = !ld && wen;
    assign last_bit = (bit_q == LAST_BIT);
    assign dflt     = OFS_W'(default_offset({ld, sel1, sel0}));

    // State register: reset entry depends on the mode strap.
    always_ff @(posedge wclk) begin
        if (mrst)
            state_q <= ld ? WS_SER_EMPTY : WS_PAR_EMPTY;
        else
            state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_PAR_EMPTY: if (hit) state_d = WS_PAR_FULL;
            WS_PAR_FULL:  if (hit) state_d = WS_PAR_EMPTY;
            WS_SER_EMPTY: if (hit && last_bit) state_d = WS_SER_FULL;
            WS_SER_FULL:  if (hit && last_bit) state_d = WS_SER_EMPTY;
            default:      state_d = WS_PAR_EMPTY;
        endcase
    end

    // Output decode.
    always_comb begin
        upd_empty_par = 1'b0;
        upd_full_par  = 1'b0;
        upd_empty_ser = 1'b0;
        upd_full_ser  = 1'b0;
        ser_mode      = 1'b0;
        unique case (state_q)
            WS_PAR_EMPTY: upd_empty_par = hit;
            WS_PAR_FULL:  upd_full_par  = hit;
            WS_SER_EMPTY: begin
                ser_mode      = 1'b1;
                upd_empty_ser = hit;
            end
            WS_SER_FULL: begin
                ser_mode     = 1'b1;
                upd_full_ser = hit;
            end
            default: ;
        endcase
    end

    // Bit counter for serial loading.
    always_ff @(posedge wclk) begin
        if (mrst)
            bit_q <= '0;
        else if (hit && ser_mode)
            bit_q <= last_bit ? '0 : bit_q + 1'b1;
    end

    // Offset registers.
    always_ff @(posedge wclk) begin
        if (mrst) begin
            empty_ofs <= dflt;
            full_ofs  <= dflt;
        end else begin
            if (upd_empty_par) empty_ofs <= wdata;
            if (upd_full_par)  full_ofs  <= wdata;
            if (upd_empty_ser) empty_ofs[bit_q] <= sdin;
            if (upd_full_ser)  full_ofs[bit_q]  <= sdin;
        end
    end

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             rclk,
    input  logic             mrst,
    input  logic             ld,
    input  logic             ren,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic [OFS_W-1:0] rdata
);

    rd_state_e        state_q, state_d;
    logic             hit;
    logic [OFS_W-1:0] sel_ofs;

    assign hit = !ld && ren;

    // State register.
    always_ff @(posedge rclk) begin
        if (mrst)
            state_q <= RS_EMPTY;
        else
            state_q <= state_d;
    end

    // Next state and word selection.
    always_comb begin
        state_d = state_q;
        sel_ofs = empty_ofs;
        unique case (state_q)
            RS_EMPTY: begin
                sel_ofs = empty_ofs;
                if (hit) state_d = RS_FULL;
            end
            RS_FULL: begin
                sel_ofs = full_ofs;
                if (hit) state_d = RS_EMPTY;
            end
            default: state_d = RS_EMPTY;
        endcase
    end

    // Readback register.
    always_ff @(posedge rclk) begin
        if (mrst)
            rdata <= '0;
        else if (hit)
            rdata <= sel_ofs;
    end

endmodule

// File: rtl/ofs_flag_regs.sv
module ofs_flag_regs #(
    parameter int DEPTH = 2048,
    localparam int OFS_W = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             ld,
    input  logic             sel1,
    input  logic             sel0,
    input  logic             wen,
    input  logic             ren,
    input  logic             sdin,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic [OFS_W-1:0] rdata
);

    logic ser_mode;

    ofs_wr_ctrl #(.OFS_W(OFS_W)) u_wr (
        .wclk      (wclk),
        .mrst      (mrst),
        .ld        (ld),
        .sel1      (sel1),
        .sel0      (sel0),
        .wen       (wen),
        .sdin      (sdin),
        .wdata     (wdata),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .ser_mode  (ser_mode)
    );

    ofs_rd_port #(.OFS_W(OFS_W)) u_rd (
        .rclk      (rclk),
        .mrst      (mrst),
        .ld        (ld),
        .ren       (ren),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rdata     (rdata)
    );

endmodule

// File: rtl/ofs_flag_regs_chk.sv
module ofs_flag_regs_chk #(
    parameter int OFS_W = 11
) (
    input logic             wclk,
    input logic             rclk,
    input logic             mrst,
    input logic             ld,
    input logic             wen,
    input logic             ren,
    input logic             ser_mode,
    input logic [OFS_W-1:0] wdata,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs,
    input logic [OFS_W-1:0] rdata
);

    // R6
    wr_hold_chk: assert property (@(posedge wclk) disable iff (mrst)
        ld |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R4
    ser_one_bit_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!ld && wen && ser_mode) |=>
            (($countones(empty_ofs ^ $past(empty_ofs)) +
              $countones(full_ofs ^ $past(full_ofs))) <= 1));

    // R3
    par_word_chk: assert property (@(posedge wclk) disable iff (mrst)
        (!ld && wen && !ser_mode) |=>
            (empty_ofs == $past(wdata) || full_ofs == $past(wdata)));

    // R8
    rd_hold_chk: assert property (@(posedge rclk) disable iff (mrst)
        ld |=> $stable(rdata));

    // R7
    rd_word_chk: assert property (@(posedge rclk) disable iff (mrst)
        (!ld && ren) |=>
            (rdata == $past(empty_ofs) || rdata == $past(full_ofs)));

endmodule

bind ofs_flag_regs ofs_flag_regs_chk #(.OFS_W(OFS_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .mrst      (mrst),
    .ld        (ld),
    .wen       (wen),
    .ren       (ren),
    .ser_mode  (ser_mode),
    .wdata     (wdata),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rdata     (rdata)
);

// File: tb/sim_ofs_flag_regs.sv
module sim_ofs_flag_regs;

    localparam int DEPTH = 2048;
    localparam int W     = $clog2(DEPTH);

    logic         clk = 1'b0;
    logic         mrst, ld, sel1, sel0, wen, ren, sdin;
    logic [W-1:0] wdata;
    logic [W-1:0] empty_ofs, full_ofs, rdata;

    always #5 clk = ~clk;

    ofs_flag_regs #(.DEPTH(DEPTH)) u0 (
        .wclk(clk), .rclk(clk), .mrst(mrst), .ld(ld), .sel1(sel1), .sel0(sel0),
        .wen(wen), .ren(ren), .sdin(sdin), .wdata(wdata),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rdata(rdata)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state
    logic [W-1:0] m_e, m_f, m_q;
    logic         m_ser, m_wp, m_rp;
    int           m_cnt;

    function automatic logic [W-1:0] dflt(input logic l, input logic s1, input logic s0);
        case ({l, s1, s0})
            3'b100:  return W'(1023);
            3'b010:  return W'(511);
            3'b001:  return W'(255);
            3'b000:  return W'(127);
            3'b011:  return W'(63);
            3'b110:  return W'(31);
            3'b101:  return W'(15);
            default: return W'(7);
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string otag, input string rtag,
                       input logic i_mrst, input logic i_ld, input logic i_s1,
                       input logic i_s0, input logic i_wen, input logic i_ren,
                       input logic i_sdin, input logic [W-1:0] i_wd);
        @(negedge clk);
        mrst = i_mrst; ld = i_ld; sel1 = i_s1; sel0 = i_s0;
        wen = i_wen; ren = i_ren; sdin = i_sdin; wdata = i_wd;
        @(posedge clk);
        if (i_mrst) begin
            m_ser = i_ld; m_e = dflt(i_ld, i_s1, i_s0); m_f = m_e;
            m_wp = 1'b0; m_rp = 1'b0; m_cnt = 0; m_q = '0;
        end else begin
            if (!i_ld && i_ren) begin
                m_q  = m_rp ? m_f : m_e;
                m_rp = ~m_rp;
            end
            if (!i_ld && i_wen) begin
                if (m_ser) begin
                    if (m_wp) m_f[m_cnt] = i_sdin;
                    else      m_e[m_cnt] = i_sdin;
                    m_cnt++;
                    if (m_cnt == W) begin
                        m_cnt = 0;
                        m_wp  = ~m_wp;
                    end
                end else begin
                    if (m_wp) m_f = i_wd;
                    else      m_e = i_wd;
                    m_wp = ~m_wp;
                end
            end
        end
        #1;
        check(otag, "empty_ofs", empty_ofs, m_e);
        check(otag, "full_ofs", full_ofs, m_f);
        check(rtag, "rdata", rdata, m_q);
    endtask

    initial begin
        mrst = 1'b1; ld = 1'b1; sel1 = 1'b0; sel0 = 1'b0;
        wen = 1'b0; ren = 1'b0; sdin = 1'b0; wdata = '0;

        // R2 / R9: every strap combination loads its default, readback cleared
        for (int k = 0; k < 8; k++) begin
            cyc("R2", "R9", 1'b1, k[2], k[1], k[0], 1'b0, 1'b0, 1'b0, '0);
            cyc("R2", "R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        end

        // R1: strap low selects word mode, strap high selects bit mode
        cyc("R2", "R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        cyc("R1", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, W'(300));
        cyc("R2", "R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        cyc("R1", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, W'(300));

        // R3 / R7 / R8 / R6 in word mode
        cyc("R2", "R9", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, W'(5));
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, W'(2047));
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        cyc("R6", "R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, W'(99));
        cyc("R6", "R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, W'(0));
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, W'(0));
        // R5: serial input ignored in word mode
        cyc("R5", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, W'(64));

        // R10: write pointer parked at full, reset, next write goes to empty
        cyc("R3", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, W'(700));
        cyc("R10", "R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc("R10", "R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, W'(33));

        // R4 / R5 bit mode: fill empty, then full, then wrap
        cyc("R2", "R9", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 2 * W + 3; i++)
            cyc(i == 0 ? "R5" : "R4", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                1'b0, i[0], '1);
        cyc("R4", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        cyc("R4", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        // R10: reset mid-bit sequence restarts at empty bit 0
        cyc("R10", "R9", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        cyc("R10", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        cyc("R10", "R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);

        // Constrained random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic r_rst, r_ld;
            r_rst = ($urandom % 150) == 0;
            r_ld  = r_rst ? 1'($urandom) : (($urandom % 4) == 0);
            cyc(m_ser ? "R4" : "R3", "R7", r_rst, r_ld, 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule